// File: doc/BRIEF.md
# Latched Serial-to-Parallel Sink Driver Core

This block is the logic core of an eight-channel low-side driver with a serial input. Data is moved into a shift register one bit at a time. A strobe then copies the whole register into a bank of holding latches, and an active-low enable decides whether the held pattern reaches the drivers. Each output bit means that one open-drain sink is conducting. A cascade bit taken from the last register stage can feed the serial input of a further device, so several devices can be loaded from one serial stream.

The serial clock, strobe, clear and data pins are slow external signals. A fast system clock samples them through a two-flop synchroniser. The block reacts to rising edges it detects on the synchronised serial clock and strobe. An external controller uses it in three steps: shift a long word through the chain, pulse the strobe to update every channel together, and use the enable to blank all channels without losing the stored pattern.

Top module: `ser_sink_drv`

## Requirements
- R1: On each detected rising edge of `sclk_in`, stage 0 takes the value of `sdata_in` and every other stage takes the value of the stage below it.
- R2: `cascade_out` always equals the highest stage. After N shifts, the bit shifted in first appears there once N equals WIDTH, so two chained devices hold a 16-bit word with the first bit in the far device's top stage.
- R3: A detected rising edge of `strobe_in` copies every register stage into its latch. With no strobe edge, the latches keep their value.
- R4: While the synchronised `clr_n_in` is low, the shift register is 0. The latches are not changed, so `sink_on` keeps its value until the next strobe.
- R5: While `oe_n_in` is high, `sink_on` is all zeros. Raising or lowering the enable leaves the latch contents unchanged.
- R6: While `oe_n_in` is low, `sink_on[i]` equals latch i, where 1 means the sink on channel i conducts.
- R7: After `rst_n` goes low, the register, the latches, `sink_on` and `cascade_out` are all 0.
- R8: A transition on `sclk_in`, `strobe_in` or `clr_n_in` that is first sampled at system edge k takes effect on the register outputs after edge k+2.
- R9: If a clear and a shift take effect in the same cycle, the clear wins. A strobe in that same cycle latches the register value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all slow inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, acts on its rising edge |
| sdata_in | input | 1 | Serial data bit |
| strobe_in | input | 1 | Latch strobe, acts on its rising edge |
| clr_n_in | input | 1 | Active-low clear of the shift register |
| oe_n_in | input | 1 | Active-low output enable |
| sink_on | output | WIDTH | Sink enables, 1 = conducting |
| cascade_out | output | 1 | Top register stage, drives the next device in a chain |

## Verification
The bench targets the 16-bit chained load. A wrong shift direction or a cascade tap on the wrong stage would put the two bytes in the wrong devices or reverse their bits. It also checks that the outputs stay still before the strobe, because a design whose latches were transparent would show partial patterns during shifting. A clear that reached the latches, or an enable that wiped them, would show up as a changed pattern when the enable is lowered again or after the clear. The coincident clear, shift and strobe case exposes a shift that wins over the clear, since that would leave a non-zero register for the next strobe, and a latch that captured the value after the clear.

// File: rtl/ser_sink_drv.sv
module ser_sink_drv #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             sdata_in,
  input  logic             strobe_in,
  input  logic             clr_n_in,
  input  logic             oe_n_in,
  output logic [WIDTH-1:0] sink_on,
  output logic             cascade_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]     sclk_sy, strb_sy, clr_sy, dat_sy;
  logic             sclk_d, strb_d;
  logic             sclk_s, strb_s, clr_s, data_s;
  logic             shift_fire, strobe_fire;
  logic [WIDTH-1:0] sreg, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      strb_sy <= '0;
      clr_sy  <= '0;
      dat_sy  <= '0;
      sclk_d  <= 1'b0;
      strb_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[TOP-1:0], sclk_in};
      strb_sy <= {strb_sy[TOP-1:0], strobe_in};
      clr_sy  <= {clr_sy[TOP-1:0],  clr_n_in};
      dat_sy  <= {dat_sy[TOP-1:0],  sdata_in};
      sclk_d  <= sclk_s;
      strb_d  <= strb_s;
    end
  end

  assign sclk_s      = sclk_sy[TOP];
  assign strb_s      = strb_sy[TOP];
  assign clr_s       = clr_sy[TOP];
  assign data_s      = dat_sy[TOP];
  assign shift_fire  = sclk_s & ~sclk_d;
  assign strobe_fire = strb_s & ~strb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sreg <= '0;
    else if (!clr_s)     sreg <= '0;
    else if (shift_fire) sreg <= {sreg[WIDTH-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           latch_q <= '0;
    else if (strobe_fire) latch_q <= sreg;
  end

  assign sink_on     = oe_n_in ? '0 : latch_q;
  assign cascade_out = sreg[WIDTH-1];

endmodule

// File: rtl/ser_sink_drv_chk.sv
module ser_sink_drv_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n_in,
  input logic [WIDTH-1:0] sink_on,
  input logic             cascade_out,
  input logic [WIDTH-1:0] sreg,
  input logic [WIDTH-1:0] latch_q,
  input logic             data_s,
  input logic             shift_fire,
  input logic             strobe_fire,
  input logic             clr_s
);

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && clr_s) |=> (sreg[0] == $past(data_s)) && (sreg[WIDTH-1:1] == $past(sreg[WIDTH-2:0]))); // R1

  AST_CASCADE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && clr_s) |=> cascade_out == $past(sreg[WIDTH-2])); // R2

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fire |=> latch_q == $past(sreg)); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_fire |=> $stable(latch_q)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (sreg == '0) && !cascade_out); // R4

  AST_BLANK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_in |-> sink_on == '0); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !clr_s) |=> sreg == '0); // R9

endmodule

bind ser_sink_drv ser_sink_drv_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n_in(oe_n_in), .sink_on(sink_on),
  .cascade_out(cascade_out), .sreg(sreg), .latch_q(latch_q), .data_s(data_s),
  .shift_fire(shift_fire), .strobe_fire(strobe_fire), .clr_s(clr_s)
);

// File: tb/ser_sink_drv_tb_top.sv
`timescale 1ns/1ps
module ser_sink_drv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, strb = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [7:0] sink_a, sink_b;
  logic cas_a, cas_b;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ser_sink_drv dut_i (.clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(sdat),
    .strobe_in(strb), .clr_n_in(clr_n), .oe_n_in(oe_n), .sink_on(sink_a), .cascade_out(cas_a));
  ser_sink_drv dut_b_i (.clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(cas_a),
    .strobe_in(strb), .clr_n_in(clr_n), .oe_n_in(oe_n), .sink_on(sink_b), .cascade_out(cas_b));

  // Reference model: input history, actions two edges after first sample
  logic [3:0] hs, ht, hc, hd, hb;
  logic [7:0] ma, mb, la, lb;
  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '0; ht = '0; hc = '0; hd = '0; hb = '0;
      ma = '0; mb = '0; la = '0; lb = '0;
    end else begin
      logic [7:0] na, nb;
      hs = {hs[2:0], sclk}; ht = {ht[2:0], strb}; hc = {hc[2:0], clr_n};
      hd = {hd[2:0], sdat}; hb = {hb[2:0], ma[7]};
      na = ma; nb = mb;
      if (!hc[2]) begin na = '0; nb = '0; end
      else if (hs[2] && !hs[3]) begin na = {ma[6:0], hd[2]}; nb = {mb[6:0], hb[2]}; end
      if (ht[2] && !ht[3]) begin la = ma; lb = mb; end
      ma = na; mb = nb;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R8 model", {sink_b, sink_a}, oe_n ? 16'h0 : {lb, la});
      chk("R2 model", {14'h0, cas_b, cas_a}, {14'h0, mb[7], ma[7]});
    end
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdat = b; wait_n(6); sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_strobe();
    wait_n(6); strb = 1'b1; wait_n(6); strb = 1'b0; wait_n(6);
  endtask

  task automatic pulse_clear();
    clr_n = 1'b0; wait_n(6); clr_n = 1'b1; wait_n(6);
  endtask

  initial begin
    wait_n(4); rst_n = 1'b1; wait_n(4);
    chk("R7 sinks", {sink_b, sink_a}, 16'h0);
    chk("R7 cascade", {14'h0, cas_b, cas_a}, 16'h0);

    shift_word(16'hA53C);
    chk("R3 no strobe yet", {sink_b, sink_a}, 16'h0);
    chk("R2 cascade chain", {14'h0, cas_b, cas_a}, {14'h0, 1'b1, 1'b0});
    pulse_strobe();
    chk("R3 R6 latched word", {sink_b, sink_a}, 16'hA53C);

    oe_n = 1'b1; wait_n(2);
    chk("R5 blanked", {sink_b, sink_a}, 16'h0);
    oe_n = 1'b0; wait_n(2);
    chk("R5 latches kept", {sink_b, sink_a}, 16'hA53C);

    pulse_clear();
    chk("R4 clear keeps sinks", {sink_b, sink_a}, 16'hA53C);
    chk("R4 clear zeroes cascade", {14'h0, cas_b, cas_a}, 16'h0);
    pulse_strobe();
    chk("R4 register was cleared", {sink_b, sink_a}, 16'h0);

    shift_bit(1'b1);
    pulse_strobe();
    chk("R1 stage0 takes input", {sink_b, sink_a}, 16'h0001);
    for (int i = 0; i < 7; i++) shift_bit(1'b0);
    chk("R2 bit reaches top stage", {14'h0, cas_b, cas_a}, 16'h0001);
    shift_bit(1'b0);
    pulse_strobe();
    chk("R1 bit crosses into next device", {sink_b, sink_a}, 16'h0100);

    // R8 latency: strobe sampled at edge k shows after edge k+2
    shift_word(16'h5AC3);
    @(negedge clk); strb = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 not yet after k+1", {sink_b, sink_a}, 16'h0100);
    @(negedge clk);
    chk("R8 visible after k+2", {sink_b, sink_a}, 16'h5AC3);
    wait_n(4); strb = 1'b0; wait_n(6);

    // R9: clear, shift and strobe together
    shift_word(16'h3CF0);
    sdat = 1'b1; wait_n(6);
    sclk = 1'b1; strb = 1'b1; clr_n = 1'b0; wait_n(6);
    sclk = 1'b0; strb = 1'b0; clr_n = 1'b1; wait_n(6);
    chk("R9 strobe took pre-clear value", {sink_b, sink_a}, 16'h3CF0);
    chk("R9 clear won over shift", {14'h0, cas_b, cas_a}, 16'h0);
    pulse_strobe();
    chk("R9 register empty", {sink_b, sink_a}, 16'h0);

    rst_n = 1'b0; wait_n(2);
    chk("R7 reset clears outputs", {sink_b, sink_a}, 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule